// File: doc/BRIEF.md
# Converter Serial Command Port

This block is the serial command port of a data converter's on-chip controller. A host shifts bytes in on a serial data line, framed by an active-low select and clocked by a serial clock. The port sits in command mode and takes the first eight bits as a command byte. A register-access command is followed by a 32-bit word. On a write the word goes into an offset, gain, channel-setup or configuration register. On a read the port shifts the register out MSB first. A conversion command passes a setup pointer and an operation code to a separate conversion engine over a request/done handshake. The result comes back into a conversion data register and raises a data-ready flag.

The port has no way to recover framing except in-band. A long run of ones followed by a single zero (fifteen all-ones bytes and then 0xFE) puts it back into command mode from any state. The configuration register also carries a soft-reset handshake: writing the reset bit restores every register to its default and sets a reset-valid flag.

All serial inputs are sampled in the system clock domain. Edges of the serial clock are found by comparing it with its value one clock earlier.

Top module: `adc_cmd_port`

## Requirements
- R1: After rst_n is released, sdo, conv_req and data_ready are 0. Every offset register, setup register and the configuration register reads 0, and every gain register reads GAIN_ONE.
- R2: A command byte with bit 7 = 0 is a register access. Its fields are as follows.
  - Bit 6 selects the direction (0 write, 1 read) and bit 2 is ignored.
  - Bits 5:3 select the target: 001 offset, 010 gain, 011 channel setup, 100 configuration, 101 conversion data (read only).
  - Bits 1:0 select one of four registers.
  - A write takes the next 32 bits, MSB first, as the new value. A read returns the register on sdo, MSB first.
- R3: sdi is taken on rising serial-clock edges and sdo changes only on falling edges. The first bit of a read word is on sdo before the first data rising edge, and sdo holds still while cs_n is high.
- R4: A command byte with bit 7 = 1 is a conversion command. Its fields are as follows.
  - Bit 6 requests continuous mode.
  - Bits 5:3 are a setup pointer p.
  - Bits 2:0 are the operation: 000 normal, 001 self offset, 010 self gain, 101 system offset, 110 system gain. Codes 011, 100 and 111 are ignored.
  - conv_setup carries setup p. For even p this is bits 31:16 of setup register p/2, and for odd p it is bits 15:0. For example, 0x99 requests a self-offset calibration on pointer 3, which is the low half of setup register 1.
- R5: conv_req is held, together with stable conv_ptr, conv_type and conv_setup, until conv_done arrives. A single request then drops. Conversion commands received while conv_req is high are ignored.
- R6: conv_done latches conv_data into the conversion data register and sets data_ready. Reading the conversion data register clears data_ready.
- R7: A conversion command in continuous mode keeps conv_req high across conv_done. The NULL command 0x00 clears data_ready and leaves the continuous request running. Any valid register-access command ends it.
- R8: A run of at least 127 consecutive ones on sdi (fifteen 0xFF bytes plus the leading seven ones of 0xFE), followed by a zero, returns the port to command mode with a cleared bit count. The following apply around this sequence:
  - That zero is not decoded as a command.
  - A data word that was open when the run began is completed with ones.
  - Fourteen 0xFF bytes followed by 0xFE are not enough. The 0xFE is then decoded as a system-gain request on pointer 7.
- R9: Raising cs_n clears the bit count but keeps the mode, so a word or command restarts from its first bit.
- R10: Configuration register layout:
  - Bit 29 is the reset request. Writing it as 1 sets offsets and setups to 0 and gains to GAIN_ONE, and leaves the configuration register at 0x3000_0000 (reset request plus reset-valid bit 28).
  - Reading the configuration register clears the reset-valid bit after the value is shifted out.
  - Writing bit 29 as 0 completes the cycle.
- R11: Configuration bits 31:30 always read 0, and bit 28 cannot be written.
- R12: Register-access commands with target 000 (other than 0x00), 110 or 111, or a write to target 101, change nothing and leave the port in command mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, MSB first |
| conv_req | output | 1 | Conversion/calibration request to the engine |
| conv_cont | output | 1 | Request is continuous |
| conv_ptr | output | 3 | Setup pointer of the request |
| conv_type | output | 3 | Operation code of the request |
| conv_setup | output | 16 | Selected 16-bit setup word |
| conv_done | input | 1 | Engine finished one result |
| conv_data | input | 32 | Result word from the engine |
| data_ready | output | 1 | Unread result present |

## Verification
The bound checker watches the following on every cycle:
- the request handshake: the request is held until done, its arguments stay stable while it is up, and it never carries a reserved operation;
- that a request can only start after a select-low cycle;
- that data_ready rises only after conv_done;
- that sdo is silent while the port is deselected.

Register contents, the field decoding of command bytes, setup-half selection, the sync threshold, the soft-reset handshake and the effect of deselecting mid-word all depend on multi-byte serial sequences. Only the bench's scenarios can show these, by sweeping every register select, every pointer and every operation code and comparing the shifted-out words with values computed from the requirements.

// File: rtl/adc_cmd_port.sv
module adc_cmd_port #(
  parameter int          SYNC_BYTES = 15,
  parameter logic [31:0] GAIN_ONE   = 32'h0100_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        sdi,
  output logic        sdo,
  output logic        conv_req,
  output logic        conv_cont,
  output logic [2:0]  conv_ptr,
  output logic [2:0]  conv_type,
  output logic [15:0] conv_setup,
  input  logic        conv_done,
  input  logic [31:0] conv_data,
  output logic        data_ready
);
  localparam int ONES_RUN = 8 * SYNC_BYTES + 7;
  localparam int OW       = $clog2(ONES_RUN + 1);

  typedef enum logic [1:0] {M_CMD, M_WR, M_RD} mode_t;

  mode_t       mode;
  logic        sclk_q;
  logic [4:0]  bcnt;
  logic [30:0] sh;
  logic [31:0] sout;
  logic [OW-1:0] ones;
  logic [2:0]  tgt;
  logic [1:0]  sel;
  logic [31:0] offs [4];
  logic [31:0] gain [4];
  logic [31:0] setup [4];
  logic [31:0] cfg, dreg;

  wire        rise    = !cs_n && sclk && !sclk_q;
  wire        fall    = !cs_n && !sclk && sclk_q;
  wire [31:0] word    = {sh, sdi};
  wire [7:0]  cbyte   = word[7:0];
  wire        resync  = rise && !sdi && (ones == OW'(ONES_RUN));
  wire        type_ok = cbyte[2:0] inside {3'b000, 3'b001, 3'b010, 3'b101, 3'b110};
  wire        acc_ok  = (cbyte[5:3] inside {3'b001, 3'b010, 3'b011, 3'b100}) ||
                        (cbyte[5:3] == 3'b101 && cbyte[6]);
  wire [31:0] sreg    = setup[cbyte[5:4]];
  wire [15:0] shalf   = cbyte[3] ? sreg[15:0] : sreg[31:16];

  assign sdo = (mode == M_RD) && sout[31];

  function automatic logic [31:0] rdmux(input logic [2:0] t, input logic [1:0] s);
    case (t)
      3'b001:  rdmux = offs[s];
      3'b010:  rdmux = gain[s];
      3'b011:  rdmux = setup[s];
      3'b100:  rdmux = cfg;
      3'b101:  rdmux = dreg;
      default: rdmux = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;  mode <= M_CMD;  bcnt <= '0;  sh <= '0;  sout <= '0;
      ones <= '0;  tgt <= '0;  sel <= '0;  cfg <= '0;  dreg <= '0;
      for (int i = 0; i < 4; i++) begin
        offs[i] <= '0;  gain[i] <= GAIN_ONE;  setup[i] <= '0;
      end
      data_ready <= 1'b0;  conv_req <= 1'b0;  conv_cont <= 1'b0;
      conv_ptr <= '0;  conv_type <= '0;  conv_setup <= '0;
    end else begin
      sclk_q <= sclk;
      if (conv_req && conv_done) begin
        dreg       <= conv_data;
        data_ready <= 1'b1;
        if (!conv_cont) conv_req <= 1'b0;
      end
      if (cs_n) bcnt <= '0;
      if (fall && mode == M_RD && bcnt != '0) sout <= {sout[30:0], 1'b0};
      if (rise) begin
        sh   <= word[30:0];
        bcnt <= bcnt + 5'd1;
        ones <= !sdi ? '0 : (ones == OW'(ONES_RUN) ? ones : ones + OW'(1));
        if (resync) begin
          mode <= M_CMD;
          bcnt <= '0;
        end else begin
          case (mode)
            M_CMD: if (bcnt == 5'd7) begin
              bcnt <= '0;
              if (cbyte[7]) begin
                if (!conv_req && type_ok) begin
                  conv_req   <= 1'b1;
                  conv_cont  <= cbyte[6];
                  conv_ptr   <= cbyte[5:3];
                  conv_type  <= cbyte[2:0];
                  conv_setup <= shalf;
                end
              end else if (cbyte == 8'h00) begin
                data_ready <= 1'b0;
              end else if (acc_ok) begin
                tgt <= cbyte[5:3];
                sel <= cbyte[1:0];
                if (conv_cont) begin
                  conv_cont <= 1'b0;
                  conv_req  <= 1'b0;
                end
                if (cbyte[6]) begin
                  mode <= M_RD;
                  sout <= rdmux(cbyte[5:3], cbyte[1:0]);
                  if (cbyte[5:3] == 3'b100) cfg[28] <= 1'b0;
                  if (cbyte[5:3] == 3'b101) data_ready <= 1'b0;
                end else begin
                  mode <= M_WR;
                end
              end
            end
            M_WR: if (bcnt == 5'd31) begin
              mode <= M_CMD;
              case (tgt)
                3'b001: offs[sel]  <= word;
                3'b010: gain[sel]  <= word;
                3'b011: setup[sel] <= word;
                default: begin
                  if (word[29]) begin
                    for (int i = 0; i < 4; i++) begin
                      offs[i] <= '0;  gain[i] <= GAIN_ONE;  setup[i] <= '0;
                    end
                    cfg <= 32'h3000_0000;
                  end else begin
                    cfg <= {3'b000, cfg[28], word[27:0]};
                  end
                end
              endcase
            end
            default: if (bcnt == 5'd31) mode <= M_CMD;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/adc_cmd_port_chk.sv
module adc_cmd_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sdo,
  input logic        conv_req,
  input logic        conv_cont,
  input logic [2:0]  conv_ptr,
  input logic [2:0]  conv_type,
  input logic [15:0] conv_setup,
  input logic        conv_done,
  input logic        data_ready
);
  a_r3_sdo_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> $stable(sdo));

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_done && !conv_cont |=> conv_req);

  a_r5_args_stable: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && $past(conv_req) |-> $stable(conv_type) && $stable(conv_ptr) && $stable(conv_setup));

  a_r4_no_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> conv_type inside {3'b000, 3'b001, 3'b010, 3'b101, 3'b110});

  a_r4_req_from_port: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> !$past(cs_n));

  a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(conv_done));
endmodule

bind adc_cmd_port adc_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo),
  .conv_req(conv_req), .conv_cont(conv_cont), .conv_ptr(conv_ptr),
  .conv_type(conv_type), .conv_setup(conv_setup), .conv_done(conv_done),
  .data_ready(data_ready)
);

// File: tb/adc_cmd_port_tb.sv
module adc_cmd_port_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] GONE       = 32'h0100_0000;

  logic        clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic        sdo, conv_req, conv_cont, conv_done = 0, data_ready;
  logic [2:0]  conv_ptr, conv_type;
  logic [15:0] conv_setup;
  logic [31:0] conv_data = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  adc_cmd_port u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int b);
    pat = 32'(32'h1357_9BDF * (a * 8 + b + 1)) ^ 32'h8000_0001;
  endfunction

  task automatic xfer(input logic [31:0] v, input int n, output logic [31:0] r);
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i]; sclk = 0; repeat (2) @(negedge clk);
      r = {r[30:0], sdo}; sclk = 1; repeat (2) @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    logic [31:0] r;
    xfer({24'h0, b}, 8, r);
  endtask

  task automatic wr(input logic [7:0] b, input logic [31:0] w);
    logic [31:0] r;
    xfer({24'h0, b}, 8, r);
    xfer(w, 32, r);
  endtask

  task automatic rd(input logic [7:0] b, output logic [31:0] r);
    xfer({24'h0, b}, 8, r);
    xfer(32'h0, 32, r);
  endtask

  task automatic done_pulse(input logic [31:0] d);
    conv_data = d; conv_done = 1; @(negedge clk);
    conv_done = 0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, sv, exp16;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(sdo == 0 && conv_req == 0 && data_ready == 0, "R1 outputs", {sdo, conv_req, data_ready}, 0);
    cs_n = 0; @(negedge clk);
    rd(8'h48, r); check(r == 0, "R1 offset0", r, 0);
    rd(8'h52, r); check(r == GONE, "R1 gain2", r, GONE);
    rd(8'h60, r); check(r == 0, "R1 config", r, 0);
    rd(8'h5B, r); check(r == 0, "R1 setup3", r, 0);

    // R2 write/read sweep over every register kind and select
    for (int k = 1; k <= 3; k++)
      for (int s = 0; s < 4; s++) wr(8'((k << 3) | s), pat(k, s));
    for (int k = 1; k <= 3; k++)
      for (int s = 0; s < 4; s++) begin
        rd(8'(8'h40 | (k << 3) | s), r);
        check(r == pat(k, s), "R2 R3 readback", r, pat(k, s));
      end
    rd(8'h4D, r); check(r == pat(1, 1), "R2 bit2 ignored", r, pat(1, 1));

    // R11 config reserved and read-only bits
    wr(8'h20, 32'hDFFF_FFFF);
    rd(8'h60, r); check(r == 32'h0FFF_FFFF, "R11 config mask", r, 32'h0FFF_FFFF);
    wr(8'h20, 32'h0);

    // R4 R5 R6 sweep of every pointer and operation code
    for (int p = 0; p < 8; p++)
      for (int t = 0; t < 8; t++) begin
        cmd(8'(8'h80 | (p << 3) | t));
        if (t == 3 || t == 4 || t == 7) begin
          check(conv_req == 0, "R4 reserved op ignored", conv_req, 0);
        end else begin
          sv = pat(3, p >> 1);
          exp16 = (p % 2 == 1) ? {16'h0, sv[15:0]} : {16'h0, sv[31:16]};
          check(conv_req == 1 && conv_ptr == 3'(p) && conv_type == 3'(t), "R4 request fields",
                {conv_req, conv_ptr, conv_type}, {1'b1, 3'(p), 3'(t)});
          check(conv_setup == exp16[15:0], "R4 setup half", conv_setup, exp16);
          done_pulse(pat(p, t) ^ 32'h5A5A_0000);
          check(conv_req == 0 && data_ready == 1, "R5 R6 done", {conv_req, data_ready}, 1);
          rd(8'h68, r);
          check(r == (pat(p, t) ^ 32'h5A5A_0000), "R6 data read", r, pat(p, t) ^ 32'h5A5A_0000);
          check(data_ready == 0, "R6 read clears ready", data_ready, 0);
        end
      end

    // R4 specific byte 0x99
    cmd(8'h99);
    sv = pat(3, 1);
    check(conv_type == 3'b001 && conv_ptr == 3'd3 && conv_setup == sv[15:0], "R4 0x99",
          {conv_type, conv_ptr, conv_setup}, {3'b001, 3'd3, sv[15:0]});
    done_pulse(32'h1);

    // R5 busy: second conversion command ignored
    cmd(8'h80);
    cmd(8'h8A);
    check(conv_type == 0 && conv_ptr == 0, "R5 busy ignore", {conv_type, conv_ptr}, 0);
    done_pulse(32'h2);
    check(conv_req == 0, "R5 single drop", conv_req, 0);

    // R7 continuous mode and NULL
    cmd(8'hD0);
    done_pulse(32'hCAFE_0001);
    check(conv_req == 1 && data_ready == 1, "R7 continuous held", {conv_req, data_ready}, 2'b11);
    cmd(8'h00);
    check(conv_req == 1 && conv_cont == 1 && data_ready == 0, "R7 null",
          {conv_req, conv_cont, data_ready}, 3'b110);
    done_pulse(32'hCAFE_0002);
    rd(8'h68, r);
    check(r == 32'hCAFE_0002 && conv_req == 0, "R7 access ends continuous", r, 32'hCAFE_0002);

    // R9 deselect mid-command and mid-word
    xfer(32'hA, 4, r);
    cs_n = 1; repeat (3) @(negedge clk); cs_n = 0; @(negedge clk);
    rd(8'h49, r); check(r == pat(1, 1), "R9 partial command dropped", r, pat(1, 1));
    cmd(8'h0A);
    xfer(32'h0000_BEEF, 16, r);
    cs_n = 1; repeat (3) @(negedge clk); cs_n = 0; @(negedge clk);
    xfer(32'h1234_5678, 32, r);
    rd(8'h4A, r); check(r == 32'h1234_5678, "R9 word restarts, mode kept", r, 32'h1234_5678);

    // R8 sync from the middle of a write
    cmd(8'h08);
    xfer(32'hABC, 12, r);
    for (int i = 0; i < 15; i++) cmd(8'hFF);
    cmd(8'hFE);
    check(conv_req == 0, "R8 terminator not decoded", conv_req, 0);
    rd(8'h48, r); check(r == 32'hABCF_FFFF, "R8 open word filled with ones", r, 32'hABCF_FFFF);
    for (int i = 0; i < 14; i++) cmd(8'hFF);
    cmd(8'hFE);
    check(conv_req == 1 && conv_type == 3'b110 && conv_ptr == 3'd7, "R8 short run decodes",
          {conv_req, conv_type, conv_ptr}, {1'b1, 3'b110, 3'd7});
    done_pulse(32'h3);

    // R10 soft reset handshake
    wr(8'h20, 32'h2000_0000);
    rd(8'h60, r); check(r == 32'h3000_0000, "R10 reset flags", r, 32'h3000_0000);
    rd(8'h60, r); check(r == 32'h2000_0000, "R10 valid cleared by read", r, 32'h2000_0000);
    rd(8'h49, r); check(r == 0, "R10 offset cleared", r, 0);
    rd(8'h53, r); check(r == GONE, "R10 gain default", r, GONE);
    rd(8'h5A, r); check(r == 0, "R10 setup cleared", r, 0);
    wr(8'h20, 32'h0);
    rd(8'h60, r); check(r == 0, "R10 completed", r, 0);

    // R12 unknown targets and write to read-only target
    cmd(8'h30);
    cmd(8'h28);
    cmd(8'h04);
    rd(8'h50, r); check(r == GONE, "R12 no mode change", r, GONE);
    rd(8'h48, r); check(r == 0, "R12 no register change", r, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule